// File: doc/BRIEF.md
# GPIO Port Controller with Set, Clear and Toggle Aliases

This block controls one port of 32 pads from a simple synchronous register bus. For each pin it decides who drives the pad. Either the port itself owns the pin, and then firmware-written output-value and output-enable bits drive it, or ownership is released and one of eight peripheral functions drives it. The function is chosen by a 3-bit code held in three parallel bit-planes. Pull-up and pull-down enables go straight to the pad cell. The pad input level is synchronized and can be read back.

Every control register has four word addresses. The first is a plain read and write location. The other three are write-only aliases: one sets bits, one clears them and one inverts them. Bits written as 1 act and bits written as 0 are untouched. Firmware can therefore change a single pin without a read-modify-write, even if other agents change other bits of the same register. Open-drain signalling needs no special mode. Firmware keeps the output value at 0 and switches the output enable to pull the line low or release it.

Top module: `gpio_atomic_port`

## Requirements
- R1: After reset, the ownership register reads all ones. Output enable, output value, all three function planes, pull-up and pull-down read zero.
- R2: The byte address bits [7:4] select the register: 0 ownership, 1 output enable, 2 output value, 3/4/5 function planes 0/1/2, 6 pull-up, 7 pull-down, 8 pin value. Bits [3:2] select the operation, with 1 as the set alias. A write to the set alias ORs the write data into the register.
- R3: Operation code 2 is the clear alias. A write to it clears the register bits that are 1 in the write data and keeps the others.
- R4: Operation code 3 is the toggle alias. A write to it inverts the register bits that are 1 in the write data and keeps the others.
- R5: Operation code 0 is the direct location. A write to it replaces the whole register, and a read of it returns the register contents.
- R6: Reads of any alias address (operation code 1, 2 or 3) return zero. Writes to the pin-value register have no effect on it.
- R7: For a pin whose ownership bit is 1, pad_out equals its output-value bit and pad_oe equals its output-enable bit.
- R8: For a pin whose ownership bit is 0, pad_out and pad_oe come from peripheral function k. Here k = {plane2, plane1, plane0} with plane 0 as the LSB, and function k of pin i is bit k*32+i of periph_out and periph_oe.
- R9: For an owned pin with output value 0, toggling its output-enable bit alternately drives the pad low (pad_oe=1, pad_out=0) and releases it (pad_oe=0). The other pins are unaffected.
- R10: pad_pu and pad_pd follow the pull-up and pull-down registers whatever the ownership. Both set selects keeper mode, and neither set leaves the pad floating.
- R11: A change on pad_in appears in the pin-value register after the second rising clock edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| periph_out | input | 256 | Output levels of the eight peripheral functions, function-major |
| periph_oe | input | 256 | Output enables of the eight peripheral functions, function-major |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Pad output level |
| pad_oe | output | 32 | Pad output driver enable |
| pad_pu | output | 32 | Pad pull-up enable |
| pad_pd | output | 32 | Pad pull-down enable |

## Verification
The hardest case to reach from the ports is a port where many pins use different peripheral functions, some owned and some released, in the same cycle. A single function value per test would never show a wrong bit-plane ordering or a swapped function index. The stimulus writes the three function planes with alternating bit patterns, so that pin i selects function i mod 8. It gives every function a distinct output pattern and then gives ownership of half the port back. In one step this exposes plane order, function indexing and the ownership mux on all 32 pins.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int PINS      = 32;
    localparam int FSEL_W    = 3;
    localparam int NFUNC     = 1 << FSEL_W;
    localparam int NREG      = 8;
    localparam int ADDR_W    = 8;
    localparam int REG_IDX_W = 4;

    localparam int REG_OWN = 0;
    localparam int REG_OE  = 1;
    localparam int REG_OV  = 2;
    localparam int REG_FS0 = 3;
    localparam int REG_PU  = 6;
    localparam int REG_PD  = 7;
    localparam int REG_PIN = 8;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_TGL   = 2'd3
    } alias_op_e;
endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_port_pkg::*;
#(
    parameter int             W   = 32,
    parameter logic [W-1:0]   RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  alias_op_e     op,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  q
);
    logic [W-1:0] q_nxt;

    always_comb begin
        unique case (op)
            OP_WRITE: q_nxt = wdata;
            OP_SET:   q_nxt = q | wdata;
            OP_CLR:   q_nxt = q & ~wdata;
            OP_TGL:   q_nxt = q ^ wdata;
            default:  q_nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST;
        else if (wr_en)
            q <= q_nxt;
    end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_port_pkg::*;
(
    input  logic              own,
    input  logic              gp_out,
    input  logic              gp_oe,
    input  logic [FSEL_W-1:0] fsel,
    input  logic [NFUNC-1:0]  fn_out,
    input  logic [NFUNC-1:0]  fn_oe,
    output logic              pin_out,
    output logic              pin_oe
);
    always_comb begin
        if (own) begin
            pin_out = gp_out;
            pin_oe  = gp_oe;
        end else begin
            pin_out = fn_out[fsel];
            pin_oe  = fn_oe[fsel];
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else begin
            stage[0] <= d;
            for (int s = 1; s < STAGES; s++)
                stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_atomic_port.sv
module gpio_atomic_port
    import gpio_port_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr_en,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [PINS-1:0]        bus_wdata,
    output logic [PINS-1:0]        bus_rdata,
    input  logic [NFUNC*PINS-1:0]  periph_out,
    input  logic [NFUNC*PINS-1:0]  periph_oe,
    input  logic [PINS-1:0]        pad_in,
    output logic [PINS-1:0]        pad_out,
    output logic [PINS-1:0]        pad_oe,
    output logic [PINS-1:0]        pad_pu,
    output logic [PINS-1:0]        pad_pd
);
    logic [REG_IDX_W-1:0]       reg_idx;
    alias_op_e                  op;
    logic [NREG-1:0][PINS-1:0]  reg_q;
    logic [PINS-1:0]            pin_val;

    assign reg_idx = bus_addr[7:4];
    assign op      = alias_op_e'(bus_addr[3:2]);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        localparam logic [PINS-1:0] RV = (r == REG_OWN) ? '1 : '0;
        gpio_alias_reg #(.W(PINS), .RST(RV)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bus_wr_en && (reg_idx == REG_IDX_W'(r))),
            .op    (op),
            .wdata (bus_wdata),
            .q     (reg_q[r])
        );
    end

    gpio_in_sync #(.W(PINS), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_val)
    );

    always_comb begin
        bus_rdata = '0;
        if (op == OP_WRITE) begin
            if (reg_idx < REG_IDX_W'(NREG))
                bus_rdata = reg_q[reg_idx[2:0]];
            else if (reg_idx == REG_IDX_W'(REG_PIN))
                bus_rdata = pin_val;
        end
    end

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic [NFUNC-1:0]  fo;
        logic [NFUNC-1:0]  fe;
        logic [FSEL_W-1:0] fs;
        for (genvar f = 0; f < NFUNC; f++) begin : g_fn
            assign fo[f] = periph_out[f*PINS + i];
            assign fe[f] = periph_oe[f*PINS + i];
        end
        for (genvar b = 0; b < FSEL_W; b++) begin : g_fs
            assign fs[b] = reg_q[REG_FS0 + b][i];
        end
        gpio_pin_mux u_mux (
            .own     (reg_q[REG_OWN][i]),
            .gp_out  (reg_q[REG_OV][i]),
            .gp_oe   (reg_q[REG_OE][i]),
            .fsel    (fs),
            .fn_out  (fo),
            .fn_oe   (fe),
            .pin_out (pad_out[i]),
            .pin_oe  (pad_oe[i])
        );
    end

    assign pad_pu = reg_q[REG_PU];
    assign pad_pd = reg_q[REG_PD];
endmodule

// File: rtl/gpio_atomic_port_chk.sv
module gpio_atomic_port_chk
    import gpio_port_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr_en,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [PINS-1:0]        bus_wdata,
    input  logic [PINS-1:0]        bus_rdata,
    input  logic [PINS-1:0]        pad_in,
    input  logic [PINS-1:0]        pad_out,
    input  logic [PINS-1:0]        pad_oe,
    input  logic [PINS-1:0]        pad_pu,
    input  logic [PINS-1:0]        pad_pd,
    input  logic [NREG-1:0][PINS-1:0] ctl_q,
    input  logic [PINS-1:0]        pin_val
);
    localparam logic [5:0] OV_SET = 6'(REG_OV * 4 + 1);
    localparam logic [5:0] OV_CLR = 6'(REG_OV * 4 + 2);
    localparam logic [5:0] OV_TGL = 6'(REG_OV * 4 + 3);

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr[7:2] == OV_SET) |=>
        (ctl_q[REG_OV] == ($past(ctl_q[REG_OV]) | $past(bus_wdata)))); // R2

    AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr[7:2] == OV_CLR) |=>
        ((ctl_q[REG_OV] & $past(bus_wdata)) == '0 &&
         (ctl_q[REG_OV] & ~$past(bus_wdata)) == ($past(ctl_q[REG_OV]) & ~$past(bus_wdata)))); // R3

    AST_TGL_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr[7:2] == OV_TGL) |=>
        ((ctl_q[REG_OV] ^ $past(ctl_q[REG_OV])) == $past(bus_wdata))); // R4

    AST_ALIAS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[3:2] != 2'b00) |-> (bus_rdata == '0)); // R6

    AST_OWNED_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_out ^ ctl_q[REG_OV]) | (pad_oe ^ ctl_q[REG_OE])) & ctl_q[REG_OWN]) == '0); // R7

    AST_PULL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu == ctl_q[REG_PU]) && (pad_pd == ctl_q[REG_PD])); // R10

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (pin_val == $past(pad_in, 2))); // R11
endmodule

bind gpio_atomic_port gpio_atomic_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd),
    .ctl_q     (reg_q),
    .pin_val   (pin_val)
);

// File: tb/sim_gpio_atomic_port.sv
`timescale 1ns/1ps
module sim_gpio_atomic_port;
    import gpio_port_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  bus_wr_en = 1'b0;
    logic [ADDR_W-1:0]     bus_addr = '0;
    logic [PINS-1:0]       bus_wdata = '0;
    logic [PINS-1:0]       bus_rdata;
    logic [NFUNC*PINS-1:0] periph_out = '0;
    logic [NFUNC*PINS-1:0] periph_oe = '0;
    logic [PINS-1:0]       pad_in = '0;
    logic [PINS-1:0]       pad_out, pad_oe, pad_pu, pad_pd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_atomic_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_out(periph_out),
        .periph_oe(periph_oe), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    function automatic logic [7:0] adr(int r, int op);
        return 8'((r << 4) | (op << 2));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int r, int op, logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = adr(r, op); bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(int r, int op, output logic [31:0] d);
        bus_addr = adr(r, op);
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(REG_OWN, 0, v); check("R1 own", v, 32'hFFFF_FFFF);
        for (int r = 1; r < NREG; r++) begin
            rd(r, 0, v); check("R1 ctl", v, 32'h0);
        end
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 pad_pu", pad_pu, 32'h0);
    endtask

    task automatic t_set_clr_tgl();
        logic [31:0] v;
        wr(REG_OV, 1, 32'h0000_00F0);
        wr(REG_OV, 1, 32'h0F00_0000);
        rd(REG_OV, 0, v); check("R2 set", v, 32'h0F00_00F0);
        wr(REG_OV, 2, 32'h0000_00A0);
        rd(REG_OV, 0, v); check("R3 clr", v, 32'h0F00_0050);
        wr(REG_OV, 3, 32'hFFFF_0000);
        rd(REG_OV, 0, v); check("R4 tgl", v, 32'hF0FF_0050);
        wr(REG_PD, 1, 32'h8000_0001);
        wr(REG_PD, 3, 32'h0000_0003);
        rd(REG_PD, 0, v); check("R4 tgl pd", v, 32'h8000_0002);
        wr(REG_PD, 0, 32'h0);
    endtask

    task automatic t_direct();
        logic [31:0] v;
        wr(REG_OE, 0, 32'h1234_5678);
        rd(REG_OE, 0, v); check("R5 write", v, 32'h1234_5678);
        wr(REG_OE, 0, 32'h0000_0000);
        rd(REG_OE, 0, v); check("R5 rewrite", v, 32'h0);
    endtask

    task automatic t_sync();
        logic [31:0] v;
        @(negedge clk); pad_in = 32'hDEAD_BEEF;
        @(negedge clk); rd(REG_PIN, 0, v); check("R11 one edge", v, 32'h0);
        @(negedge clk); rd(REG_PIN, 0, v); check("R11 two edges", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_alias_read();
        logic [31:0] v;
        rd(REG_OV, 1, v); check("R6 set read", v, 32'h0);
        rd(REG_OWN, 2, v); check("R6 clr read", v, 32'h0);
        rd(REG_OV, 3, v); check("R6 tgl read", v, 32'h0);
        wr(REG_PIN, 0, 32'h0);
        wr(REG_PIN, 2, 32'hFFFF_FFFF);
        rd(REG_PIN, 0, v); check("R6 pin write ignored", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_owned();
        wr(REG_OV, 0, 32'hA5A5_A5A5);
        wr(REG_OE, 0, 32'hFFFF_0000);
        check("R7 pad_out", pad_out, 32'hA5A5_A5A5);
        check("R7 pad_oe", pad_oe, 32'hFFFF_0000);
    endtask

    task automatic t_func();
        logic [31:0] exp_o, exp_e, pat;
        for (int k = 0; k < NFUNC; k++) begin
            pat = 32'h0101_0101 * (k + 1) ^ (32'h1 << (k * 3));
            periph_out[k*PINS +: PINS] = pat;
            periph_oe[k*PINS +: PINS]  = ~pat;
        end
        wr(3, 0, 32'hAAAA_AAAA);
        wr(4, 0, 32'hCCCC_CCCC);
        wr(5, 0, 32'hF0F0_F0F0);
        wr(REG_OWN, 2, 32'hFFFF_FFFF);
        for (int i = 0; i < PINS; i++) begin
            exp_o[i] = periph_out[(i % 8) * PINS + i];
            exp_e[i] = periph_oe[(i % 8) * PINS + i];
        end
        check("R8 func out", pad_out, exp_o);
        check("R8 func oe", pad_oe, exp_e);
        wr(REG_OWN, 1, 32'h0000_FFFF);
        check("R8 mixed out", pad_out, {exp_o[31:16], 16'hA5A5});
        check("R8 mixed oe", pad_oe, {exp_e[31:16], 16'h0000});
    endtask

    task automatic t_open_drain();
        wr(REG_OWN, 1, 32'hFFFF_FFFF);
        wr(REG_OE, 0, 32'h0);
        wr(REG_OV, 2, 32'h0000_0008);
        wr(REG_OE, 3, 32'h0000_0008);
        check("R9 drive low oe", pad_oe, 32'h0000_0008);
        check("R9 drive low out", pad_out & 32'h8, 32'h0);
        wr(REG_OE, 3, 32'h0000_0008);
        check("R9 release", pad_oe, 32'h0);
        wr(REG_OE, 3, 32'h0000_0008);
        check("R9 low again", pad_oe, 32'h0000_0008);
    endtask

    task automatic t_pull();
        wr(REG_PU, 1, 32'h0000_0003);
        wr(REG_PD, 1, 32'h0000_0006);
        check("R10 pu", pad_pu, 32'h3);
        check("R10 pd keeper pin1", pad_pd, 32'h6);
        wr(REG_OWN, 2, 32'hFFFF_FFFF);
        check("R10 pu released", pad_pu, 32'h3);
        check("R10 pd released", pad_pd, 32'h6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clr_tgl();
        t_direct();
        t_sync();
        t_alias_read();
        t_owned();
        t_func();
        t_open_drain();
        t_pull();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule